// File: doc/BRIEF.md
# Rounding Shift-Right Narrow Unit

This unit is one step of a vector datapath. It takes a 128-bit source vector of unsigned wide elements. It shifts every element right by an immediate amount, rounding or truncating, and keeps the low half of each shifted value. The narrowed lanes are packed into a 64-bit result, and that result is merged into the current 128-bit destination value. An issue stage presents the operands with `in_valid`, and the merged destination value appears one clock later with `out_valid`.

A single seven-bit immediate, split into a four-bit high part and a three-bit low part, selects both the narrow element width and the shift amount. A half-select bit picks the merge style. The result either goes to the low half with the high half zeroed, or goes to the high half with the low half kept. Two flags report encodings the unit does not execute: one for encodings that belong to another instruction class and one for undefined encodings. In both cases the destination value is passed through unchanged.

Top module: `simd_rnd_shrn_narrow`

## Requirements
- R1: The narrow element width N is 8 when imm_hi is 0001, 16 when imm_hi is 001x, and 32 when imm_hi is 01xx. The wide source element is 2N bits, and the unit processes 64/N lanes (8, 4 or 2).
- R2: The shift amount is 2N minus the unsigned value of {imm_hi, imm_lo}. It therefore lies between 1 and N.
- R3: With round_en=0, each narrow lane is the low N bits of the wide element shifted right by the shift amount, with the wide element treated as unsigned.
- R4: With round_en=1, 2^(shift-1) is added to the wide element before the shift. The sum is kept one bit wider than the element so that the carry is not lost. The all-ones inputs of every width are covered.
- R5: Wide lane e occupies src_vec bits [2N*e +: 2N]. Its result goes to narrow lane e, bits [N*e +: N] of the 64-bit result, with lane 0 in the least significant bits.
- R6: With q_upper=0 on a legal encoding, dst_next[63:0] is the result and dst_next[127:64] is zero.
- R7: With q_upper=1 on a legal encoding, dst_next[127:64] is the result and dst_next[63:0] equals dst_cur[63:0].
- R8: imm_hi=0000 raises alt_flag, clears undef_flag, and makes dst_next equal dst_cur.
- R9: imm_hi[3]=1 raises undef_flag, clears alt_flag, and makes dst_next equal dst_cur.
- R10: Outputs are registered. out_valid is in_valid delayed by one clock. After reset, out_valid, dst_next and both flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Operands and immediate are valid this cycle |
| src_vec | input | 128 | Source vector of wide elements |
| dst_cur | input | 128 | Current destination value |
| q_upper | input | 1 | 1 writes the high half and keeps the low half; 0 writes the low half and zeroes the high half |
| imm_hi | input | 4 | High part of the packed immediate (width select) |
| imm_lo | input | 3 | Low part of the packed immediate |
| round_en | input | 1 | 1 rounds, 0 truncates |
| out_valid | output | 1 | dst_next and flags are valid |
| dst_next | output | 128 | Merged destination value |
| undef_flag | output | 1 | Encoding is undefined |
| alt_flag | output | 1 | Encoding belongs to another instruction class |

## Verification
The bench builds the unit with the package defaults: a 64-bit narrow result out of a 128-bit vector, and the three element widths 8, 16 and 32. These defaults bring every lane count (8, 4 and 2) within reach. For each width, the bench drives the minimum shift of 1, the maximum shift equal to N, and all-ones elements, so that the rounding carry reaches the top of the sum. Both merge halves, both flag encodings and a few hundred random immediates are compared lane by lane against an independent model in the bench.

// File: rtl/rshrn_pkg.sv
package rshrn_pkg;
  localparam int VEC_W    = 128;
  localparam int NARROW_W = VEC_W / 2;
  localparam int ESZ_BASE = 8;
  localparam int SIZE_CNT = 3;
  localparam int SH_W     = 6;

  typedef enum logic [1:0] {ESZ_8 = 2'd0, ESZ_16 = 2'd1, ESZ_32 = 2'd2} esz_e;

  typedef struct packed {
    logic            alt;
    logic            undef;
    esz_e            esz;
    logic [SH_W-1:0] shamt;
  } dec_t;

  function automatic int esize_bits(esz_e esz);
    return ESZ_BASE << int'(esz);
  endfunction

  function automatic dec_t decode_imm(logic [3:0] hi, logic [2:0] lo);
    dec_t d;
    int   eb;
    d.alt   = (hi == 4'b0000);
    d.undef = hi[3];
    if (hi[2])      d.esz = ESZ_32;
    else if (hi[1]) d.esz = ESZ_16;
    else            d.esz = ESZ_8;
    eb      = esize_bits(d.esz);
    d.shamt = SH_W'(2 * eb - int'({hi, lo}));
    return d;
  endfunction
endpackage

// File: rtl/rshrn_decode.sv
module rshrn_decode
  import rshrn_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [3:0] imm_hi,
  input  logic [2:0] imm_lo,
  output dec_t       dec,
  output logic       legal
);
  logic [SH_W-1:0] ebits;

  always_comb begin
    dec   = decode_imm(imm_hi, imm_lo);
    legal = !dec.alt && !dec.undef;
    ebits = SH_W'(esize_bits(dec.esz));
  end

  p_shift_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && legal) |-> (dec.shamt >= SH_W'(1) && dec.shamt <= ebits));

  p_flag_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> !(dec.alt && dec.undef));
endmodule

// File: rtl/rshrn_lane.sv
module rshrn_lane #(
  parameter int WIDE_W = 16,
  parameter int SH_W   = 6
) (
  input  logic [WIDE_W-1:0]   elem,
  input  logic [SH_W-1:0]     shamt,
  input  logic                rnd,
  output logic [WIDE_W/2-1:0] res
);
  localparam int NAR_W = WIDE_W / 2;

  logic [WIDE_W:0] bias;
  logic [WIDE_W:0] sum;

  always_comb begin
    if (rnd && shamt != '0)
      bias = {{WIDE_W{1'b0}}, 1'b1} << (shamt - SH_W'(1));
    else
      bias = '0;
    sum = {1'b0, elem} + bias;
    res = NAR_W'(sum >> shamt);
  end
endmodule

// File: rtl/rshrn_size_path.sv
module rshrn_size_path
  import rshrn_pkg::*;
#(
  parameter int ESZ_IDX = 0
) (
  input  logic [VEC_W-1:0]    src_vec,
  input  logic [SH_W-1:0]     shamt,
  input  logic                rnd,
  output logic [NARROW_W-1:0] result
);
  localparam int NAR_W  = ESZ_BASE << ESZ_IDX;
  localparam int WIDE_W = 2 * NAR_W;
  localparam int LANES  = NARROW_W / NAR_W;

  for (genvar e = 0; e < LANES; e++) begin : g_lane
    rshrn_lane #(.WIDE_W(WIDE_W), .SH_W(SH_W)) i_lane (
      .elem  (src_vec[WIDE_W*e +: WIDE_W]),
      .shamt (shamt),
      .rnd   (rnd),
      .res   (result[NAR_W*e +: NAR_W])
    );
  end
endmodule

// File: rtl/simd_rnd_shrn_narrow.sv
module simd_rnd_shrn_narrow
  import rshrn_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] src_vec,
  input  logic [VEC_W-1:0] dst_cur,
  input  logic             q_upper,
  input  logic [3:0]       imm_hi,
  input  logic [2:0]       imm_lo,
  input  logic             round_en,
  output logic             out_valid,
  output logic [VEC_W-1:0] dst_next,
  output logic             undef_flag,
  output logic             alt_flag
);
  dec_t                dec;
  logic                legal;
  logic [NARROW_W-1:0] path_res [SIZE_CNT];
  logic [NARROW_W-1:0] narrow_res;
  logic [VEC_W-1:0]    merged;

  rshrn_decode i_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .imm_hi   (imm_hi),
    .imm_lo   (imm_lo),
    .dec      (dec),
    .legal    (legal)
  );

  for (genvar s = 0; s < SIZE_CNT; s++) begin : g_size
    rshrn_size_path #(.ESZ_IDX(s)) i_path (
      .src_vec (src_vec),
      .shamt   (dec.shamt),
      .rnd     (round_en),
      .result  (path_res[s])
    );
  end

  always_comb begin
    narrow_res = path_res[0];
    for (int s = 1; s < SIZE_CNT; s++)
      if (int'(dec.esz) == s) narrow_res = path_res[s];
    if (!legal)       merged = dst_cur;
    else if (q_upper) merged = {narrow_res, dst_cur[NARROW_W-1:0]};
    else              merged = {{NARROW_W{1'b0}}, narrow_res};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      dst_next   <= '0;
      undef_flag <= 1'b0;
      alt_flag   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        dst_next   <= merged;
        undef_flag <= dec.undef;
        alt_flag   <= dec.alt;
      end
    end
  end

  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_keep_on_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (alt_flag || undef_flag)) |-> (dst_next == $past(dst_cur)));

  p_upper_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !alt_flag && !undef_flag && !$past(q_upper))
      |-> (dst_next[VEC_W-1:NARROW_W] == '0));

  p_lower_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !alt_flag && !undef_flag && $past(q_upper))
      |-> (dst_next[NARROW_W-1:0] == $past(dst_cur[NARROW_W-1:0])));
endmodule

// File: tb/test_simd_rnd_shrn_narrow.sv
`timescale 1ns/1ps
module test_simd_rnd_shrn_narrow;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] src_vec = '0;
  logic [127:0] dst_cur = '0;
  logic         q_upper = 1'b0;
  logic [3:0]   imm_hi = 4'd1;
  logic [2:0]   imm_lo = 3'd0;
  logic         round_en = 1'b0;
  logic         out_valid;
  logic [127:0] dst_next;
  logic         undef_flag;
  logic         alt_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [127:0] dst;
    logic         undef;
    logic         alt;
    string        tag;
  } exp_t;

  exp_t exp_q[$];

  always #5 clk = ~clk;

  simd_rnd_shrn_narrow i_simd_rnd_shrn_narrow (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_vec(src_vec),
    .dst_cur(dst_cur), .q_upper(q_upper), .imm_hi(imm_hi), .imm_lo(imm_lo),
    .round_en(round_en), .out_valid(out_valid), .dst_next(dst_next),
    .undef_flag(undef_flag), .alt_flag(alt_flag)
  );

  function automatic exp_t model(logic [127:0] s, logic [127:0] d, logic q,
                                 logic [3:0] h, logic [2:0] l, logic r, string tag);
    exp_t        x;
    int          e, sh;
    logic [63:0] res;
    x.tag   = tag;
    x.alt   = (h == 4'd0);
    x.undef = h[3];
    if (x.alt || x.undef) begin
      x.dst = d;
      return x;
    end
    e   = h[2] ? 32 : (h[1] ? 16 : 8);
    sh  = 2 * e - int'({h, l});
    res = '0;
    for (int i = 0; i < 64 / e; i++) begin
      logic [64:0] w;
      w = 65'(s >> (i * 2 * e)) & ((65'd1 << (2 * e)) - 65'd1);
      if (r) w = w + (65'd1 << (sh - 1));
      w = w >> sh;
      res = res | ((64'(w) & ((64'd1 << e) - 64'd1)) << (i * e));
    end
    x.dst = q ? {res, d[63:0]} : {64'd0, res};
    return x;
  endfunction

  task automatic send(input logic [127:0] s, input logic [127:0] d, input logic q,
                      input logic [3:0] h, input logic [2:0] l, input logic r,
                      input string tag);
    @(negedge clk);
    #1;
    exp_q.push_back(model(s, d, q, h, l, r, tag));
    in_valid = 1'b1; src_vec = s; dst_cur = d; q_upper = q;
    imm_hi = h; imm_lo = l; round_en = r;
  endtask

  task automatic send_sh(input logic [127:0] s, input logic [127:0] d, input logic q,
                         input int e, input int sh, input logic r, input string tag);
    logic [6:0] imm;
    imm = 7'(2 * e - sh);
    send(s, d, q, imm[6:3], imm[2:0], r, tag);
  endtask

  task automatic idle();
    @(negedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid && !done) begin
      exp_t x;
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R10: unexpected out_valid, actual dst=%h expected none", dst_next);
      end else begin
        x = exp_q.pop_front();
        if (dst_next !== x.dst || undef_flag !== x.undef || alt_flag !== x.alt) begin
          fails++;
          $display("FAIL %s: actual dst=%h u=%b a=%b expected dst=%h u=%b a=%b",
                   x.tag, dst_next, undef_flag, alt_flag, x.dst, x.undef, x.alt);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [127:0] ones;
    logic [127:0] pat;
    ones = '1;
    pat  = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || dst_next !== '0 || undef_flag !== 1'b0 || alt_flag !== 1'b0) begin
      fails++;
      $display("FAIL R10: reset actual v=%b dst=%h expected v=0 dst=0", out_valid, dst_next);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int k = 0; k < 3; k++) begin
      int e;
      e = 8 << k;
      send_sh(pat, ones, 1'b0, e, 1, 1'b0, "R2_min_shift_trunc");
      send_sh(pat, ones, 1'b0, e, 1, 1'b1, "R4_min_shift_round");
      send_sh(pat, ones, 1'b1, e, e, 1'b0, "R2_max_shift_trunc");
      send_sh(pat, ones, 1'b1, e, e, 1'b1, "R4_max_shift_round");
      send_sh(ones, pat, 1'b0, e, 1, 1'b1, "R4_all_ones_carry_min");
      send_sh(ones, pat, 1'b1, e, e, 1'b1, "R4_all_ones_carry_max");
      send_sh(ones, pat, 1'b0, e, e / 2, 1'b0, "R3_all_ones_trunc");
    end
    send(128'h0007_0006_0005_0004_0003_0002_0001_0000, '0, 1'b0, 4'd1, 3'd7, 1'b0,
         "R5_lane_order_8");
    send(128'h0000_0003_0000_0002_0000_0001_0000_0000, '0, 1'b1, 4'd3, 3'd7, 1'b0,
         "R5_lane_order_16");
    send(pat, ones, 1'b0, 4'd2, 3'd3, 1'b1, "R1_size16_imm_001x");
    send(pat, ones, 1'b1, 4'd6, 3'd1, 1'b1, "R1_size32_imm_01xx");
    send(pat, ones, 1'b0, 4'd5, 3'd2, 1'b0, "R6_low_half_clear");
    send(pat, ones, 1'b1, 4'd5, 3'd2, 1'b0, "R7_high_half_keep");
    send(pat, ones, 1'b0, 4'd0, 3'd5, 1'b1, "R8_alt_encoding");
    send(pat, pat, 1'b1, 4'd0, 3'd0, 1'b0, "R8_alt_encoding_q1");
    send(pat, ones, 1'b0, 4'd8, 3'd3, 1'b1, "R9_undef_encoding");
    send(pat, pat, 1'b1, 4'd15, 3'd7, 1'b0, "R9_undef_encoding_q1");
    idle();
    idle();
    send(pat, ones, 1'b1, 4'd1, 3'd4, 1'b1, "R10_after_gap");

    for (int n = 0; n < 400; n++) begin
      logic [127:0] s, d;
      logic [3:0]   h;
      s = {$urandom, $urandom, $urandom, $urandom};
      d = {$urandom, $urandom, $urandom, $urandom};
      h = 4'($urandom_range(1, 7));
      if ($urandom_range(0, 19) == 0) h = 4'($urandom_range(0, 15));
      send(s, d, 1'($urandom), h, 3'($urandom), 1'($urandom), "R3_R4_random");
    end
    idle();
    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R10: results missing, actual pending=%0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule